// File: doc/BRIEF.md
# Programmable Sum-of-Products Plane with Complement Feedback

This block is a configurable two-level logic plane. Sixteen source signals come in: four dedicated inputs, four feedbacks from bidirectional lines and eight feedbacks from registers. From these it forms 32 logic product terms and 13 control product terms. It also forms 21 sums, each the OR of a chosen group of the logic product terms. Every source signal can feed any product term in true form, in inverted form, or not at all.

A single NOR gate watches a chosen group of logic product terms and produces a complement term. That complement term goes back into the AND plane as one more literal, and it can only be used inverted. This lets a designer write "none of these other terms is active" as one literal. A logic term that uses the complement literal is always left out of the NOR, so the feedback path can never close on itself.

All connections are held in one configuration image that is shifted in serially before use. During loading the plane drives all of its outputs to zero.

Top module: `pla_sop_array`

## Requirements
- R1: After reset, all product terms and all sums are 0 and the complement term is 1. Reset loads every configuration bit with 1.
- R2: While `cfg_en` is 1, each rising clock edge shifts `cfg_di` into the top bit of the 2189-bit image and moves every bit down by one. After 2189 shifts, the first bit shifted in sits at index 0. Layout of the image:
  - Term t (0..44) owns bits t*33 .. t*33+32. Bit t*33+j is the true literal of source j. Bit t*33+16+j is the inverted literal of source j. Bit t*33+32 is the inverted complement-term literal.
  - The source index j runs 0..3 for the dedicated inputs, 4..7 for the bidirectional lines and 8..15 for the registers.
  - Bits 1485+k select logic term k into the NOR.
  - Bits 1517+s*32+k connect logic term k to sum s.
- R3: While `cfg_en` is 1, every product-term output, every sum and `comp_o` read 0.
- R4: While `cfg_en` is 0, the image is unchanged whatever `cfg_di` does.
- R5: A logic product term is 1 exactly when every connected literal is 1.
- R6: A term with no connected literal is 1. A term that connects both polarities of any source is 0.
- R7: The control terms (image terms 32..44, output bits 0..12) follow the same rule as the logic terms.
- R8: The complement term is 1 exactly when no logic term is high among those that are both selected into the NOR and have their complement literal cleared. A term with its complement literal set is ANDed with the inverse of the complement term.
- R9: Each sum is the OR of the logic terms connected to it. A sum with no connected term is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration shifting |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | High to shift the configuration image |
| cfg_di | input | 1 | Serial configuration data |
| ded_i | input | 4 | Dedicated inputs (sources 0..3) |
| bid_i | input | 4 | Bidirectional-line feedbacks (sources 4..7) |
| reg_i | input | 8 | Register feedbacks (sources 8..15) |
| logic_pt_o | output | 32 | Logic product terms |
| ctrl_pt_o | output | 13 | Control product terms |
| sum_o | output | 21 | OR sums |
| comp_o | output | 1 | Complement term |

## Verification
The hardest case to reach is a logic term that both uses the complement literal and is selected into the NOR. It only shows anything when its own AND condition is true while every other selected term is false. The bench loads a hand-built image with exactly that arrangement. It then drives a dedicated input that makes only the self-referencing term's literals true, and checks that the complement stays 1 and the term stays 0. After that, sparse random images and random input vectors are compared against a behavioural model on every clock.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic {
    CFG_RUN  = 1'b0,
    CFG_LOAD = 1'b1
  } cfg_mode_e;

  // configuration bits owned by one product term
  function automatic int term_fuses(input int nsig);
    return 2 * nsig + 1;
  endfunction

  // total configuration image length
  function automatic int image_len(input int nsig, input int nlog,
                                   input int nctl, input int nsum);
    return (nlog + nctl) * term_fuses(nsig) + nlog + nsum * nlog;
  endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int LEN = 2189
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           shift_di,
  output logic [LEN-1:0] image_o
);

  logic [LEN-1:0] image_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) image_q <= '1;
    else if (shift_en) image_q <= {shift_di, image_q[LEN-1:1]};
  end

  assign image_o = image_q;

  // R4
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(image_q));

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> image_q[LEN-1] == $past(shift_di));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int NSIG  = 16,
  parameter int NTERM = 45,
  parameter int NLOG  = 32,
  localparam int FW   = 2 * NSIG + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSIG-1:0]     sig_i,
  input  logic [NTERM*FW-1:0] fuses_i,
  input  logic                comp_i,
  output logic [NTERM-1:0]    pt_o,
  output logic [NLOG-1:0]     free_o
);

  // 1 unless a connected literal is false
  function automatic logic term_and(input logic [NSIG-1:0] s,
                                    input logic [NSIG-1:0] tmask,
                                    input logic [NSIG-1:0] cmask);
    return ~|((~s & tmask) | (s & cmask));
  endfunction

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    localparam int B = t * FW;
    logic [NSIG-1:0] tm, cm;
    logic cu, raw;

    assign tm  = fuses_i[B +: NSIG];
    assign cm  = fuses_i[B+NSIG +: NSIG];
    assign cu  = fuses_i[B+2*NSIG];
    assign raw = term_and(sig_i, tm, cm);
    assign pt_o[t] = raw & ~(cu & comp_i);

    if (t < NLOG) begin : g_free
      assign free_o[t] = raw & ~cu;
    end

    // R6
    contra_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |(tm & cm) |-> !pt_o[t]);

    // R8
    cterm_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cu && comp_i) |-> !pt_o[t]);

    // R5
    true_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pt_o[t] |-> ((sig_i & tm) == tm) && ((sig_i & cm) == '0));
  end

endmodule

// File: rtl/pla_comp_nor.sv
module pla_comp_nor #(
  parameter int NLOG = 32
) (
  input  logic [NLOG-1:0] free_i,
  input  logic [NLOG-1:0] sel_i,
  output logic            comp_o
);

  function automatic logic nor_sel(input logic [NLOG-1:0] v,
                                   input logic [NLOG-1:0] m);
    return ~|(v & m);
  endfunction

  assign comp_o = nor_sel(free_i, sel_i);

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int NLOG = 32,
  parameter int NSUM = 21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NLOG-1:0]      pt_i,
  input  logic [NSUM*NLOG-1:0] fuses_i,
  output logic [NSUM-1:0]      sum_o
);

  function automatic logic or_sel(input logic [NLOG-1:0] v,
                                  input logic [NLOG-1:0] m);
    return |(v & m);
  endfunction

  for (genvar s = 0; s < NSUM; s++) begin : g_sum
    assign sum_o[s] = or_sel(pt_i, fuses_i[s*NLOG +: NLOG]);
  end

  // R9
  sum_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |sum_o |-> |pt_i);

endmodule

// File: rtl/pla_sop_array.sv
module pla_sop_array #(
  parameter int NDED = 4,
  parameter int NBID = 4,
  parameter int NREG = 8,
  parameter int NLOG = 32,
  parameter int NCTL = 13,
  parameter int NSUM = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_di,
  input  logic [NDED-1:0] ded_i,
  input  logic [NBID-1:0] bid_i,
  input  logic [NREG-1:0] reg_i,
  output logic [NLOG-1:0] logic_pt_o,
  output logic [NCTL-1:0] ctrl_pt_o,
  output logic [NSUM-1:0] sum_o,
  output logic            comp_o
);
  import pla_pkg::*;

  localparam int NSIG     = NDED + NBID + NREG;
  localparam int NTERM    = NLOG + NCTL;
  localparam int FW       = term_fuses(NSIG);
  localparam int AND_BITS = NTERM * FW;
  localparam int SEL_BASE = AND_BITS;
  localparam int OR_BASE  = SEL_BASE + NLOG;
  localparam int LEN      = image_len(NSIG, NLOG, NCTL, NSUM);

  cfg_mode_e        mode;
  logic [LEN-1:0]   image;
  logic [NSIG-1:0]  sig;
  logic [NTERM-1:0] pt;
  logic [NLOG-1:0]  free;
  logic [NLOG-1:0]  sel;
  logic [NSUM-1:0]  sum;
  logic             comp;
  logic             live;

  assign mode = cfg_mode_e'(cfg_en);
  assign live = (mode == CFG_RUN);
  assign sig  = {reg_i, bid_i, ded_i};
  assign sel  = image[SEL_BASE +: NLOG];

  pla_cfg_chain #(.LEN(LEN)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(cfg_en),
    .shift_di(cfg_di),
    .image_o (image)
  );

  pla_and_plane #(.NSIG(NSIG), .NTERM(NTERM), .NLOG(NLOG)) u_and (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (sig),
    .fuses_i(image[AND_BITS-1:0]),
    .comp_i (comp),
    .pt_o   (pt),
    .free_o (free)
  );

  pla_comp_nor #(.NLOG(NLOG)) u_nor (
    .free_i(free),
    .sel_i (sel),
    .comp_o(comp)
  );

  pla_or_plane #(.NLOG(NLOG), .NSUM(NSUM)) u_or (
    .clk    (clk),
    .rst_n  (rst_n),
    .pt_i   (pt[NLOG-1:0]),
    .fuses_i(image[OR_BASE +: NSUM*NLOG]),
    .sum_o  (sum)
  );

  assign logic_pt_o = live ? pt[NLOG-1:0]     : '0;
  assign ctrl_pt_o  = live ? pt[NTERM-1:NLOG] : '0;
  assign sum_o      = live ? sum              : '0;
  assign comp_o     = live & comp;

  // R3
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (logic_pt_o == '0) && (ctrl_pt_o == '0) && (sum_o == '0) && !comp_o);

  // R8
  comp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !comp_o) |-> |(logic_pt_o & sel));

endmodule

// File: tb/sim_pla_sop_array.sv
module sim_pla_sop_array;
  localparam int NSIG = 16, NLOG = 32, NCTL = 13, NSUM = 21;
  localparam int NTERM = 45, FW = 33;
  localparam int SEL_BASE = NTERM * FW;
  localparam int OR_BASE = SEL_BASE + NLOG;
  localparam int LEN = OR_BASE + NSUM * NLOG;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_en, cfg_di;
  logic [3:0] ded_i, bid_i;
  logic [7:0] reg_i;
  logic [NLOG-1:0] logic_pt_o;
  logic [NCTL-1:0] ctrl_pt_o;
  logic [NSUM-1:0] sum_o;
  logic comp_o;

  int tests = 0, fails = 0, cycles = 0;
  bit run_chk = 1'b0;
  logic [LEN-1:0] mdl;
  logic [LEN-1:0] img;

  pla_sop_array u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_di(cfg_di),
    .ded_i(ded_i), .bid_i(bid_i), .reg_i(reg_i),
    .logic_pt_o(logic_pt_o), .ctrl_pt_o(ctrl_pt_o), .sum_o(sum_o), .comp_o(comp_o)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // behavioural reference of the plane for a given image and source vector
  task automatic model(input logic [LEN-1:0] m, input logic [15:0] s,
                       output logic [31:0] p, output logic [12:0] c,
                       output logic [20:0] u, output logic cm);
    bit raw[NTERM];
    bit usec[NTERM];
    for (int t = 0; t < NTERM; t++) begin
      raw[t] = 1;
      for (int j = 0; j < NSIG; j++) begin
        if (m[t*FW + j] && !s[j]) raw[t] = 0;
        if (m[t*FW + NSIG + j] && s[j]) raw[t] = 0;
      end
      usec[t] = m[t*FW + 32];
    end
    cm = 1;
    for (int k = 0; k < NLOG; k++)
      if (m[SEL_BASE + k] && !usec[k] && raw[k]) cm = 0;
    for (int t = 0; t < NTERM; t++) begin
      bit v;
      v = raw[t] && !(usec[t] && cm);
      if (t < NLOG) p[t] = v; else c[t - NLOG] = v;
    end
    for (int q = 0; q < NSUM; q++) begin
      u[q] = 0;
      for (int k = 0; k < NLOG; k++)
        if (m[OR_BASE + q*NLOG + k] && p[k]) u[q] = 1;
    end
  endtask

  // compare with the model every clock
  always @(negedge clk) begin
    if (run_chk) begin
      if (cfg_en) begin
        chk("R3 quiet", {logic_pt_o, ctrl_pt_o, sum_o, comp_o}, 64'd0);
      end else begin
        logic [31:0] p; logic [12:0] c; logic [20:0] u; logic cm;
        model(mdl, {reg_i, bid_i, ded_i}, p, c, u, cm);
        chk("R5 logic terms", logic_pt_o, p);
        chk("R7 control terms", ctrl_pt_o, c);
        chk("R9 sums", sum_o, u);
        chk("R8 complement", comp_o, cm);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic load(input logic [LEN-1:0] im);
    for (int i = 0; i < LEN; i++) begin
      cfg_en = 1'b1;
      cfg_di = im[i];
      @(posedge clk);
      mdl = {im[i], mdl[LEN-1:1]};
      #1;
    end
    cfg_en = 1'b0;
    cfg_di = 1'b0;
  endtask

  task automatic drive(input logic [15:0] v);
    @(posedge clk); #1;
    {reg_i, bid_i, ded_i} = v;
  endtask

  task automatic sweep(input int n);
    for (int i = 0; i < n; i++) drive(16'($urandom));
  endtask

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; cfg_di = 1'b0;
    ded_i = '0; bid_i = '0; reg_i = '0;
    mdl = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset terms", {logic_pt_o, ctrl_pt_o}, 64'd0);
    chk("R1 reset sums", sum_o, 64'd0);
    chk("R1 reset complement", comp_o, 64'd1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    run_chk = 1'b1;
    sweep(20);

    // hand-built image
    img = '0;
    for (int j = 0; j < 32; j++) img[1*FW + j] = 1'b1;
    img[2*FW + 0] = 1'b1;
    img[3*FW + 16 + 15] = 1'b1;
    img[4*FW + 32] = 1'b1;
    img[5*FW + 1] = 1'b1;
    img[5*FW + 32] = 1'b1;
    for (int t = 6; t < NTERM; t++)
      for (int j = 0; j < FW; j++) img[t*FW + j] = 1'b1;
    for (int j = 0; j < FW; j++) img[32*FW + j] = 1'b0;
    img[32*FW + 1] = 1'b1;
    img[32*FW + 16 + 4] = 1'b1;
    img[SEL_BASE + 2] = 1'b1;
    img[SEL_BASE + 5] = 1'b1;
    img[OR_BASE + 0*NLOG + 2] = 1'b1;
    img[OR_BASE + 0*NLOG + 3] = 1'b1;
    img[OR_BASE + 1*NLOG + 4] = 1'b1;
    img[OR_BASE + 20*NLOG + 0] = 1'b1;
    load(img);

    drive(16'h0001);
    @(negedge clk);
    chk("R6 empty term", logic_pt_o[0], 64'd1);
    chk("R6 contradictory term", logic_pt_o[1], 64'd0);
    chk("R2 layout term2", logic_pt_o[2], 64'd1);
    chk("R8 complement low", comp_o, 64'd0);
    chk("R8 complement literal", logic_pt_o[4], 64'd1);
    chk("R9 sum1", sum_o[1], 64'd1);
    chk("R9 sum20 constant", sum_o[20], 64'd1);

    drive(16'h0002);
    @(negedge clk);
    chk("R8 self term excluded", comp_o, 64'd1);
    chk("R8 self term low", logic_pt_o[5], 64'd0);
    chk("R7 control term", ctrl_pt_o[0], 64'd1);
    chk("R5 inverted reg literal", logic_pt_o[3], 64'd1);

    drive(16'h8012);
    @(negedge clk);
    chk("R7 control blocked", ctrl_pt_o[0], 64'd0);
    chk("R5 inverted reg blocked", logic_pt_o[3], 64'd0);

    // cfg_di toggles with cfg_en low
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      cfg_di = ~cfg_di;
      {reg_i, bid_i, ded_i} = 16'($urandom);
    end
    cfg_di = 1'b0;
    drive(16'h0001);
    @(negedge clk);
    chk("R4 image held term2", logic_pt_o[2], 64'd1);
    chk("R4 image held term1", logic_pt_o[1], 64'd0);
    sweep(500);

    // sparse random images
    for (int r = 0; r < 3; r++) begin
      img = '0;
      for (int t = 0; t < NTERM; t++) begin
        int n;
        n = $urandom_range(1, 3);
        for (int q = 0; q < n; q++) begin
          int b;
          b = $urandom_range(0, 31);
          if ($urandom_range(0, 7) == 0) b = 32;
          img[t*FW + b] = 1'b1;
        end
      end
      for (int k = 0; k < NLOG; k++) img[SEL_BASE + k] = ($urandom_range(0, 2) == 0);
      for (int q = 0; q < NSUM * NLOG; q++) img[OR_BASE + q] = ($urandom_range(0, 7) == 0);
      load(img);
      sweep(2000);
    end

    run_chk = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule